// File: doc/BRIEF.md
# Access Attribute Resolution Unit

This block gives every memory reference a set of effective attributes. The references may come from the processor core or from a debug agent. Both share the one request port. The attribute set has three flags:

- whether the access may be cached;
- whether operand writes are handled precisely or imprecisely;
- whether the target is write-protected.

Two programmable address windows and one default attribute set are held in registers. A simple register write port loads them.

Each window compares the upper `TAG_W` bits of the request address against its base. A per-bit mask removes bits from the compare. If window 0 matches, its attributes apply. If it does not, window 1 is tried. If neither matches, the default attributes apply. A window whose enable bit is clear never matches. The result is registered and appears one cycle after the request strobe. A write that resolves to a write-protected attribute raises a one-cycle violation flag and is marked as not to be performed.

Top module: `attr_resolver`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle in which `req_valid` was sampled high. In a cycle after `req_valid` was low, `rsp_valid`, `rsp_wp_fault` and `rsp_allow` are all low.
- R2: A window matches when, on every tag bit (address bits `[ADDR_W-1 : ADDR_W-TAG_W]`) whose mask bit is 0, the address bit equals the base bit. A mask bit of 1 excludes that bit from the compare.
- R3: A window whose enable bit is 0 never matches, whatever its base and mask hold.
- R4: When both windows match, window 0 wins. `rsp_sel` reports the source: bit 0 means window 0, bit 1 means window 1, and 0 means the defaults. At most one bit is ever set.
- R5: When neither window matches, the response carries the default attributes.
- R6: Attribute fields use bit 0 for cacheable, bit 1 for imprecise write handling and bit 2 for write-protect. The matching source's field appears unchanged on `rsp_cacheable`, `rsp_imprecise` and `rsp_wprot`.
- R7: A write request (`req_write` = 1) that resolves to write-protect = 1 gives `rsp_wp_fault` = 1 and `rsp_allow` = 0 in its response cycle. Any other request gives `rsp_wp_fault` = 0 and `rsp_allow` = 1.
- R8: After reset, both windows are disabled and the defaults are 000 (noncacheable, precise, unprotected).
- R9: A config write with `cfg_sel` = 0 or 1 loads that window from `cfg_wdata`:
  - base in `[2*TAG_W+3 : TAG_W+4]`;
  - mask in `[TAG_W+3 : 4]`;
  - enable in `[3]`;
  - attributes in `[2:0]`.

  With `cfg_sel` = 2 it loads the defaults from `[2:0]`. With `cfg_sel` = 3 the write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config register write strobe |
| cfg_sel | input | 2 | Target: 0 window 0, 1 window 1, 2 defaults, 3 none |
| cfg_wdata | input | 2*TAG_W+4 | Config write data |
| req_valid | input | 1 | Reference strobe |
| req_addr | input | ADDR_W | Reference address |
| req_write | input | 1 | Reference is a write |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_cacheable | output | 1 | Effective cacheable flag |
| rsp_imprecise | output | 1 | Effective imprecise-write flag |
| rsp_wprot | output | 1 | Effective write-protect flag |
| rsp_sel | output | 2 | Source of the attributes (one-hot or zero) |
| rsp_wp_fault | output | 1 | Write-protect violation pulse |
| rsp_allow | output | 1 | Reference may be performed |

## Verification
The bench builds the block with `ADDR_W` = 12 and `TAG_W` = 4. With a 4-bit tag, every tag value can be applied as both a read and a write under each window setting. A sweep therefore covers every mask pattern a configuration selects, including overlap between the windows and full wildcard masks. A bench model computes the expected results from the base, mask and enable arithmetic. It is run over directed configurations and many pseudo-random configurations, so priority, disabled windows and protection faults are all reached.

// File: rtl/attr_resolver.sv
module attr_resolver #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 8,
  localparam int CFG_W = 2*TAG_W+4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_cacheable,
  output logic              rsp_imprecise,
  output logic              rsp_wprot,
  output logic [1:0]        rsp_sel,
  output logic              rsp_wp_fault,
  output logic              rsp_allow
);

  logic [TAG_W-1:0] win_base [2];
  logic [TAG_W-1:0] win_mask [2];
  logic [2:0]       win_attr [2];
  logic [1:0]       win_en;
  logic [2:0]       dflt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        win_base[i] <= '0;
        win_mask[i] <= '0;
        win_attr[i] <= '0;
      end
      win_en <= '0;
      dflt   <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0, 2'd1: begin
          win_base[cfg_sel[0]] <= cfg_wdata[2*TAG_W+3:TAG_W+4];
          win_mask[cfg_sel[0]] <= cfg_wdata[TAG_W+3:4];
          win_en[cfg_sel[0]]   <= cfg_wdata[3];
          win_attr[cfg_sel[0]] <= cfg_wdata[2:0];
        end
        2'd2:    dflt <= cfg_wdata[2:0];
        default: ;
      endcase
    end
  end

  wire [TAG_W-1:0] tag = req_addr[ADDR_W-1 -: TAG_W];
  logic [1:0] hit;

  for (genvar i = 0; i < 2; i++) begin : g_win
    assign hit[i] = win_en[i] && (((tag ^ win_base[i]) & ~win_mask[i]) == '0);
  end

  wire [1:0] pick   = {hit[1] & ~hit[0], hit[0]};
  wire [2:0] attr_c = hit[0] ? win_attr[0] : hit[1] ? win_attr[1] : dflt;
  wire       viol   = req_write & attr_c[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_wp_fault  <= 1'b0;
      rsp_allow     <= 1'b0;
      rsp_sel       <= '0;
      rsp_cacheable <= 1'b0;
      rsp_imprecise <= 1'b0;
      rsp_wprot     <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_wp_fault <= req_valid & viol;
      rsp_allow    <= req_valid & ~viol;
      if (req_valid) begin
        rsp_sel <= pick;
        {rsp_wprot, rsp_imprecise, rsp_cacheable} <= attr_c;
      end
    end
  end

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);  // R1
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_wp_fault && !rsp_allow));  // R1
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0(rsp_sel));  // R4
  AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_sel[0]) |-> $past(win_en[0]));  // R3
  AST_DEFAULT_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_sel == 2'b00) |->
      ({rsp_wprot, rsp_imprecise, rsp_cacheable} == $past(dflt)));  // R5
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_wp_fault == ($past(req_write) && rsp_wprot)));  // R7
  AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wp_fault |-> (rsp_valid && !rsp_allow));  // R7

endmodule

// File: tb/attr_resolver_test.sv
module attr_resolver_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int TW = 4;
  localparam int CW = 2*TW+4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_write = 1'b0;
  logic rsp_valid, rsp_cacheable, rsp_imprecise, rsp_wprot, rsp_wp_fault, rsp_allow;
  logic [1:0] rsp_sel;

  int vectors = 0;
  int fails = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  logic [TW-1:0] m_base [2];
  logic [TW-1:0] m_mask [2];
  logic [2:0]    m_attr [2];
  logic [1:0]    m_en;
  logic [2:0]    m_dflt;

  attr_resolver #(.ADDR_W(AW), .TAG_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_cacheable(rsp_cacheable), .rsp_imprecise(rsp_imprecise),
    .rsp_wprot(rsp_wprot), .rsp_sel(rsp_sel), .rsp_wp_fault(rsp_wp_fault), .rsp_allow(rsp_allow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_base[i] = '0;
      m_mask[i] = '0;
      m_attr[i] = '0;
    end
    m_en = '0;
    m_dflt = '0;
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [CW-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_sel = sel;
    cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel < 2) begin
      m_base[sel[0]] = data[2*TW+3:TW+4];
      m_mask[sel[0]] = data[TW+3:4];
      m_en[sel[0]]   = data[3];
      m_attr[sel[0]] = data[2:0];
    end else if (sel == 2) begin
      m_dflt = data[2:0];
    end
  endtask

  task automatic chk(input logic [TW-1:0] tag, input logic wr, input string lbl);
    logic h0, h1;
    logic [1:0] esel;
    logic [2:0] eattr;
    logic ef;
    logic [8:0] got, exp;
    string tagname;
    h0 = m_en[0] && (((tag ^ m_base[0]) & ~m_mask[0]) == 0);
    h1 = m_en[1] && (((tag ^ m_base[1]) & ~m_mask[1]) == 0);
    esel  = h0 ? 2'b01 : (h1 ? 2'b10 : 2'b00);
    eattr = h0 ? m_attr[0] : (h1 ? m_attr[1] : m_dflt);
    ef = wr & eattr[2];
    tagname = lbl;
    if (tagname == "") begin
      if (ef) tagname = "R7";
      else if (esel == 2'b01) tagname = "R4";
      else if (esel == 2'b10) tagname = "R2";
      else tagname = "R5";
    end
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr = {tag, 8'(lfsr)};
    @(negedge clk);
    req_valid = 1'b0;
    exp = {1'b1, esel, eattr, ef, ~ef, 1'b0};
    got = {rsp_valid, rsp_sel, rsp_wprot, rsp_imprecise, rsp_cacheable, rsp_wp_fault, rsp_allow, 1'b0};
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s tag=%0h wr=%0b got=%b expected=%b", tagname, tag, wr, got, exp);
    end
  endtask

  task automatic idle_chk();
    @(negedge clk);
    vectors++;
    if ({rsp_valid, rsp_wp_fault, rsp_allow} !== 3'b000) begin
      fails++;
      $display("FAIL R1 idle got=%b expected=000", {rsp_valid, rsp_wp_fault, rsp_allow});
    end
  endtask

  task automatic sweep(input string lbl);
    for (int t = 0; t < (1 << TW); t++) begin
      chk(TW'(t), 1'b0, lbl);
      chk(TW'(t), 1'b1, lbl);
    end
    idle_chk();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired got=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_chk();
    sweep("R8");
    cfg(2'd2, CW'(3'b111));
    sweep("");
    // R4: overlapping windows on tag 5, window 0 must win
    cfg(2'd0, {4'h5, 4'h0, 1'b1, 3'b001});
    cfg(2'd1, {4'h5, 4'h3, 1'b1, 3'b110});
    sweep("");
    // R3: disabling window 0 lets window 1 take over
    cfg(2'd0, {4'h5, 4'h0, 1'b0, 3'b001});
    sweep("R3");
    // R3: disabled window with full wildcard mask never matches
    cfg(2'd1, {4'h0, 4'hF, 1'b0, 3'b011});
    sweep("R3");
    // R9: cfg_sel 3 write leaves everything unchanged
    cfg(2'd3, '1);
    sweep("R9");
    // R2: wildcard window 1, exact window 0
    cfg(2'd1, {4'h0, 4'hF, 1'b1, 3'b010});
    cfg(2'd0, {4'hA, 4'h0, 1'b1, 3'b101});
    sweep("");
    for (int n = 0; n < 60; n++) begin
      lfsr = next_rand(lfsr);
      cfg(2'(lfsr[1:0] % 3), CW'(lfsr[31:20]));
      lfsr = next_rand(lfsr);
      cfg(2'(lfsr[1]), CW'(lfsr[27:16]));
      sweep("R6");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule